// File: doc/BRIEF.md
# Pause Frame Receive Throttle

This block sits beside a MAC transmitter and converts decoded IEEE 802.3 pause requests into a single transmit-hold level. The receive side hands it a one-cycle pulse for each valid pause frame, along with the frame's 16-bit quanta value. A prescaler that depends on the link rate supplies one tick per pause quantum, where a quantum is 512 bit times. The transmit side reports where each outgoing frame starts and where it ends.

The block keeps a countdown of the pause time still remaining. While the countdown is nonzero, `tx_hold` tells the transmitter not to begin another frame. The hold is a registered level, and the transmitter samples it only when it is deciding whether to start a frame. If a pause arrives in the middle of a frame, the hold stays low until that frame's end marker. It rises on that boundary, provided pause time is still left. A configuration bit makes the block disregard pause frames entirely.

Top module: `pause_rx_throttle`

## Requirements
- R1: After reset, `tx_hold` is 0 and the remaining pause count is 0.
- R2: When no frame is open, a pause pulse with nonzero quanta loads the count, and `tx_hold` reads 1 in the cycle after the pulse.
- R3: Each `quantum_tick` decrements a nonzero count by one. `tx_hold` falls on the same edge where the count reaches zero, so an XOFF of Q quanta holds for exactly Q ticks.
- R4: A pause pulse with quanta equal to zero (XON) clears the count, and `tx_hold` is 0 in the next cycle.
- R5: A new quanta value replaces the running count and is never added to it.
- R6: When a pause pulse and a tick arrive in the same cycle, the loaded value wins and that tick is dropped.
- R7: A frame is open from its `tx_sof` cycle until its `tx_eof` cycle. If `tx_sof` and `tx_eof` are both 1 in one cycle, that frame is single-cycle and opens nothing. `tx_hold` never rises while a frame is open. It rises in the cycle after `tx_eof` if the count is still nonzero.
- R8: Once `tx_hold` is 1, it stays 1 until the count reaches zero, whatever the framing inputs do.
- R9: While `ignore_pause` is 1, pause pulses have no effect, the count is forced to 0, and `tx_hold` is 0 from the next cycle.
- R10: `tx_hold` is never 1 while the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pause_valid | input | 1 | One-cycle pulse for each valid received pause frame |
| pause_quanta | input | 16 | Quanta value of that frame; 0 means XON |
| quantum_tick | input | 1 | One pulse per pause quantum elapsed |
| tx_sof | input | 1 | Transmitter starts a frame this cycle |
| tx_eof | input | 1 | Transmitter ends a frame this cycle |
| ignore_pause | input | 1 | 1 = disregard received pause frames |
| tx_hold | output | 1 | 1 = do not begin a new frame |

## Verification
The bench drives XOFF pulses while the link is idle and counts ticks to the edge where the hold drops; this separates a correct decrement from an off-by-one. An XON pulse, and a second XOFF loaded partway through a countdown, show the difference between overwriting the count and accumulating it. A pulse that coincides with a tick shows which of the two takes priority. Pauses that arrive inside an open frame, including frames that end before or after the countdown and a single-cycle frame, check that the hold waits for the frame boundary. Other cases show that a held level is never dropped early and that the ignore bit suppresses everything.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

    parameter int QUANTA_W_DEF = 16;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_BUSY = 1'b1
    } frame_e;

    typedef struct packed {
        logic hold;
    } hold_st_t;

endpackage

// File: rtl/pfr_frame_track.sv
module pfr_frame_track
    import pfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic eof,
    output logic busy_q,
    output logic busy_next
);

    frame_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sof) begin
            st_d = FR_BUSY;
        end
        if (eof) begin
            st_d = FR_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= FR_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_q    = (st_q == FR_BUSY);
    assign busy_next = (st_d == FR_BUSY);

endmodule

// File: rtl/pfr_quanta_counter.sv
module pfr_quanta_counter #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [QW-1:0] load_val,
    input  logic          tick,
    output logic [QW-1:0] count_q,
    output logic          nz_next
);

    localparam logic [QW-1:0] ZERO = '0;
    localparam logic [QW-1:0] ONE  = {{(QW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [QW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = ZERO;
        end else if (load) begin
            st_d.cnt = load_val;
        end else if (tick && (st_q.cnt != ZERO)) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.cnt;
    assign nz_next = (st_d.cnt != ZERO);

endmodule

// File: rtl/pfr_hold_gate.sv
module pfr_hold_gate
    import pfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_nz_next,
    input  logic busy_next,
    output logic hold
);

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // keep an asserted hold, otherwise raise only outside a frame
        st_d.hold = cnt_nz_next && (st_q.hold || !busy_next);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold = st_q.hold;

endmodule

// File: rtl/pause_rx_throttle.sv
module pause_rx_throttle #(
    parameter int QW = pfr_pkg::QUANTA_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pause_valid,
    input  logic [QW-1:0] pause_quanta,
    input  logic          quantum_tick,
    input  logic          tx_sof,
    input  logic          tx_eof,
    input  logic          ignore_pause,
    output logic          tx_hold
);

    logic          busy_q;
    logic          busy_next;
    logic [QW-1:0] count_q;
    logic          cnt_nz_next;
    logic          accept;

    assign accept = pause_valid && !ignore_pause;

    pfr_frame_track u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (tx_sof),
        .eof      (tx_eof),
        .busy_q   (busy_q),
        .busy_next(busy_next)
    );

    pfr_quanta_counter #(.QW(QW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ignore_pause),
        .load    (accept),
        .load_val(pause_quanta),
        .tick    (quantum_tick),
        .count_q (count_q),
        .nz_next (cnt_nz_next)
    );

    pfr_hold_gate u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_nz_next(cnt_nz_next),
        .busy_next  (busy_next),
        .hold       (tx_hold)
    );

endmodule

// File: rtl/pause_rx_throttle_chk.sv
module pause_rx_throttle_chk #(
    parameter int QW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pause_valid,
    input logic [QW-1:0] pause_quanta,
    input logic          quantum_tick,
    input logic          tx_eof,
    input logic          ignore_pause,
    input logic          tx_hold,
    input logic [QW-1:0] count_q,
    input logic          busy_q
);

    localparam logic [QW-1:0] ZERO = '0;
    localparam logic [QW-1:0] ONE  = {{(QW-1){1'b0}}, 1'b1};

    AST_XOFF_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_valid && !ignore_pause && !quantum_tick) |=> (count_q == $past(pause_quanta))); // R5

    AST_LOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_valid && !ignore_pause && quantum_tick) |=> (count_q == $past(pause_quanta))); // R6

    AST_TICK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pause_valid && !ignore_pause && quantum_tick && count_q != ZERO)
        |=> (count_q == $past(count_q) - ONE)); // R3

    AST_XON_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_valid && !ignore_pause && pause_quanta == ZERO) |=> !tx_hold); // R4

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ignore_pause |=> (!tx_hold && count_q == ZERO)); // R9

    AST_HOLD_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hold |-> (count_q != ZERO)); // R10

    AST_NO_RISE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tx_eof && !tx_hold) |=> !tx_hold); // R7

    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hold && !pause_valid && !ignore_pause && !(quantum_tick && count_q == ONE))
        |=> tx_hold); // R8

endmodule

bind pause_rx_throttle pause_rx_throttle_chk #(.QW(QW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pause_valid (pause_valid),
    .pause_quanta(pause_quanta),
    .quantum_tick(quantum_tick),
    .tx_eof      (tx_eof),
    .ignore_pause(ignore_pause),
    .tx_hold     (tx_hold),
    .count_q     (count_q),
    .busy_q      (busy_q)
);

// File: tb/sim_pause_rx_throttle.sv
`timescale 1ns/1ps
module sim_pause_rx_throttle;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pause_valid = 1'b0;
    logic [15:0] pause_quanta = '0;
    logic        quantum_tick = 1'b0;
    logic        tx_sof = 1'b0;
    logic        tx_eof = 1'b0;
    logic        ignore_pause = 1'b0;
    logic        tx_hold;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    pause_rx_throttle u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pause_valid (pause_valid),
        .pause_quanta(pause_quanta),
        .quantum_tick(quantum_tick),
        .tx_sof      (tx_sof),
        .tx_eof      (tx_eof),
        .ignore_pause(ignore_pause),
        .tx_hold     (tx_hold)
    );

    // monitor: compares the output just after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (tx_hold !== e) begin
                n_fail++;
                $display("FAIL %s: tx_hold actual=%b expected=%b", t, tx_hold, e);
            end
        end
    end

    // driver: applies one cycle of stimulus and queues the expected hold after it
    task automatic step(input bit pv, input logic [15:0] q, input bit tk,
                        input bit sof, input bit eof, input bit ign,
                        input bit exp, input string tag);
        @(negedge clk);
        pause_valid  = pv;
        pause_quanta = q;
        quantum_tick = tk;
        tx_sof       = sof;
        tx_eof       = eof;
        ignore_pause = ign;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input bit exp, input string tag);
        step(0, 16'd0, 0, 0, 0, 0, exp, tag);
    endtask

    task automatic tick(input bit exp, input string tag);
        step(0, 16'd0, 1, 0, 0, 0, exp, tag);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        n_run++;
        if (tx_hold !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: tx_hold in reset actual=%b expected=0", tx_hold);
        end
        rst_n = 1'b1;
        idle(0, "R1");
        tick(0, "R1 no count after reset");

        // XOFF 3 on idle link, count exactly three ticks
        step(1, 16'd3, 0, 0, 0, 0, 1, "R2");
        idle(1, "R3 no tick keeps hold");
        tick(1, "R3 tick1");
        tick(1, "R3 tick2");
        tick(0, "R3 tick3 releases");

        // XON release
        step(1, 16'd5, 0, 0, 0, 0, 1, "R2");
        step(1, 16'd0, 0, 0, 0, 0, 0, "R4");
        idle(0, "R4");

        // overwrite, not accumulate: 10 -> 8 -> reload 2
        step(1, 16'd10, 0, 0, 0, 0, 1, "R2");
        tick(1, "R5");
        tick(1, "R5");
        step(1, 16'd2, 0, 0, 0, 0, 1, "R5 reload");
        tick(1, "R5");
        tick(0, "R5 reload replaced count");

        // load and tick together: load wins
        step(1, 16'd2, 1, 0, 0, 0, 1, "R6");
        tick(1, "R6 tick after load");
        tick(0, "R6");

        // pause inside a frame that outlasts part of the count
        step(0, 16'd0, 0, 1, 0, 0, 0, "R7 sof");
        step(1, 16'd4, 0, 0, 0, 0, 0, "R7 pause in frame");
        tick(0, "R7 still in frame");
        step(0, 16'd0, 0, 0, 1, 0, 1, "R7 eof raises hold");
        tick(1, "R7");
        tick(1, "R7");
        tick(0, "R7 expire");

        // pause expires before the frame ends
        step(0, 16'd0, 0, 1, 0, 0, 0, "R7 sof");
        step(1, 16'd2, 0, 0, 0, 0, 0, "R7");
        tick(0, "R7");
        tick(0, "R7");
        step(0, 16'd0, 0, 0, 1, 0, 0, "R7 eof with count zero");

        // single-cycle frame opens nothing
        step(1, 16'd3, 0, 1, 1, 0, 1, "R7 single-cycle frame");
        // frame started during hold: hold stays
        step(0, 16'd0, 0, 1, 0, 0, 1, "R8 sof while held");
        tick(1, "R8");
        step(0, 16'd0, 0, 0, 1, 0, 1, "R8 eof");
        step(1, 16'd0, 0, 0, 0, 0, 0, "R4");

        // ignore bit
        step(1, 16'd5, 0, 0, 0, 1, 0, "R9 pause ignored");
        step(0, 16'd0, 0, 0, 0, 0, 0, "R9 nothing loaded");
        step(1, 16'd5, 0, 0, 0, 0, 1, "R2");
        step(0, 16'd0, 0, 0, 0, 1, 0, "R9 ignore drops hold");
        idle(0, "R9 count was cleared");

        // large quanta
        step(1, 16'hFFFF, 0, 0, 0, 0, 1, "R2 max");
        for (int i = 0; i < 4; i++) tick(1, "R3 max quanta");
        step(1, 16'd0, 0, 0, 0, 0, 0, "R4");
        idle(0, "R10");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule